// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block holds the 16-bit management registers that a MAC reads and writes to control and observe an Ethernet PHY. The host side is a plain port with a 5-bit register address, a write strobe with write data, and a read strobe. Read data depends only on the address and is always valid in the same cycle. Every address follows one of five access classes:

- writable
- read-only
- write-only
- unimplemented
- unmapped

Only writable registers ever take a write. A write-only, unimplemented or unmapped address always reads as zero.

The link bit in the basic status register is latched low, and a small state machine drives it. It has three states:

- `LNK_DOWN`: the live link is down and the latch is clear.
- `LNK_ARMED`: the live link is up but the latch has not been refreshed yet.
- `LNK_UP`: the live link is up and the latch is set.

Its transitions are:

- `LNK_DOWN` to `LNK_ARMED` when `link_up` is sampled high.
- `LNK_ARMED` to `LNK_UP` on an accepted read of address 1 while the link stays up.
- `LNK_ARMED` or `LNK_UP` to `LNK_DOWN` whenever `link_up` is sampled low.

All other cases hold the current state.

A read of the status register returns the latched bit as it stands. The refresh of the latch happens on the same clock edge that accepts that read. The gigabit status register returns a constant. The extended identifier comes from a configuration input.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, the registers read as follows: address 0 is 0x1140, address 1 is 0x7969, address 4 is 0x01E1, address 16 is 0x0068 and address 17 is 0x0000.
- R2: Addresses 4 and 16 are writable. A write stores all 16 bits, and the new value reads back from the next cycle on.
- R3: At the control register (address 0), a write with bit 15 clear is stored. A write with bit 15 set is discarded, and the old value is kept.
- R4: Read-only addresses ignore writes. Their values are: 2 reads 0x0141, 3 reads `ext_id`, 5 reads 0x01E0, 9 reads 0x1E00 and 10 reads 0x3C00.
- R5: Addresses 6, 7, 8, 15, 18 to 21, 26, 29 and 30, and every unmapped address, read as 0. Writes to them change no register.
- R6: Bit 10 of address 17 shows the value `link_up` had at the previous clock edge. All other bits of address 17 are 0.
- R7: Bit 2 of address 1 is the latched link bit. After the link comes up, it stays 0 until a read of address 1 is accepted. That read still returns 0, and later reads return 1 while the link stays up.
- R8: A `link_up` sampled low clears bit 2 of address 1 at that clock edge, with no read needed.
- R9: `rd_data` follows `addr` and `ext_id` combinationally. A read strobe at any address other than 1 leaves the latched link bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe (accepted on the clock edge) |
| rd_data | output | 16 | Read data for `addr` |
| ext_id | input | 16 | Extended identifier value |
| link_up | input | 1 | Live link state |

## Verification
A wrong link state shows at the ports within one edge. Either bit 10 of address 17 disagrees with the `link_up` sampled at the last edge, or bit 2 of address 1 rises without a status read before it or survives a low `link_up`. A stray write enable or a wrong access class shows as soon as the whole address space is read back after each write. The bench therefore reads every one of the 32 addresses after a write to each address, and compares each value with one computed from the requirements.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    typedef enum logic [2:0] {
        ACC_RW,
        ACC_RO,
        ACC_WO,
        ACC_UNIMPL,
        ACC_UNMAPPED
    } acc_e;

    typedef enum logic [1:0] {
        LNK_DOWN,
        LNK_ARMED,
        LNK_UP
    } link_e;

    localparam int REG_W    = 16;
    localparam int NUM_RW   = 3;

    localparam int STAT_LINK_BIT = 2;
    localparam int LIVE_BIT      = 10;
    localparam int CTRL_GUARD    = 15;

    localparam logic [REG_W-1:0] STATUS_BASE = 16'h7969;
    localparam logic [REG_W-1:0] ID_VALUE    = 16'h0141;
    localparam logic [REG_W-1:0] PARTNER_VAL = 16'h01E0;
    localparam logic [REG_W-1:0] GIG_CTRL    = 16'h1E00;
    localparam logic [REG_W-1:0] GIG_STATUS  = 16'h3C00;

    localparam logic [4:0]       RW_ADDR  [NUM_RW] = '{5'd0, 5'd4, 5'd16};
    localparam logic [REG_W-1:0] RW_INIT  [NUM_RW] = '{16'h1140, 16'h01E1, 16'h0068};
    localparam bit               RW_GUARD [NUM_RW] = '{1'b1, 1'b0, 1'b0};

endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_e              acc
);

    always_comb begin
        unique case (addr)
            5'd0, 5'd4, 5'd16:
                acc = ACC_RW;
            5'd1, 5'd2, 5'd3, 5'd5, 5'd9, 5'd10, 5'd17:
                acc = ACC_RO;
            5'd29:
                acc = ACC_WO;
            5'd6, 5'd7, 5'd8, 5'd15, 5'd18, 5'd19, 5'd20, 5'd21, 5'd26, 5'd30:
                acc = ACC_UNIMPL;
            default:
                acc = ACC_UNMAPPED;
        endcase
    end

endmodule

// File: rtl/phy_mgmt_link_fsm.sv
module phy_mgmt_link_fsm
    import phy_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic status_rd,
    output logic live,
    output logic latched
);

    link_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LNK_DOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LNK_DOWN:  if (link_up) state_d = LNK_ARMED;
            LNK_ARMED: begin
                if (!link_up)       state_d = LNK_DOWN;
                else if (status_rd) state_d = LNK_UP;
            end
            LNK_UP:    if (!link_up) state_d = LNK_DOWN;
            default:   state_d = LNK_DOWN;
        endcase
    end

    always_comb begin
        live    = 1'b0;
        latched = 1'b0;
        unique case (state_q)
            LNK_DOWN:  ;
            LNK_ARMED: live = 1'b1;
            LNK_UP: begin
                live    = 1'b1;
                latched = 1'b1;
            end
            default:   ;
        endcase
    end

    p_drop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (!latched && !live));

    p_live_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> live);

    p_rise_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched) |-> $past(status_rd));

endmodule

// File: rtl/phy_mgmt_rw_reg.sv
module phy_mgmt_rw_reg #(
    parameter int              ADDR_W    = 5,
    parameter int              DATA_W    = 16,
    parameter logic [ADDR_W-1:0] MY_ADDR = '0,
    parameter logic [DATA_W-1:0] INIT    = '0,
    parameter bit              GUARD_EN  = 1'b0,
    parameter int unsigned     GUARD_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] q
);

    logic hit, blocked, take;

    assign hit = wr_en && (wr_addr == MY_ADDR);

    generate
        if (GUARD_EN) begin : g_guard
            assign blocked = wr_data[GUARD_BIT];
        end else begin : g_open
            assign blocked = 1'b0;
        end
    endgenerate

    assign take = hit && !blocked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= INIT;
        else if (take) q <= wr_data;
    end

    p_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == MY_ADDR && !(GUARD_EN && wr_data[GUARD_BIT]))
        |=> q == $past(wr_data));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == MY_ADDR && !(GUARD_EN && wr_data[GUARD_BIT]))
        |=> $stable(q));

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] ext_id,
    input  logic              link_up
);

    acc_e              acc;
    logic              live, latched, status_rd, rw_we;
    logic [DATA_W-1:0] rw_q [NUM_RW];

    phy_mgmt_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .acc  (acc)
    );

    assign status_rd = rd_en && (addr == 5'd1);
    assign rw_we     = wr_en && (acc == ACC_RW);

    phy_mgmt_link_fsm u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_up   (link_up),
        .status_rd (status_rd),
        .live      (live),
        .latched   (latched)
    );

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        phy_mgmt_rw_reg #(
            .ADDR_W    (ADDR_W),
            .DATA_W    (DATA_W),
            .MY_ADDR   (RW_ADDR[g]),
            .INIT      (RW_INIT[g]),
            .GUARD_EN  (RW_GUARD[g]),
            .GUARD_BIT (CTRL_GUARD)
        ) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (rw_we),
            .wr_addr (addr),
            .wr_data (wr_data),
            .q       (rw_q[g])
        );
    end

    always_comb begin
        rd_data = '0;
        if (acc == ACC_RW || acc == ACC_RO) begin
            case (addr)
                5'd0:    rd_data = rw_q[0];
                5'd1: begin
                    rd_data = STATUS_BASE;
                    rd_data[STAT_LINK_BIT] = latched;
                end
                5'd2:    rd_data = ID_VALUE;
                5'd3:    rd_data = ext_id;
                5'd4:    rd_data = rw_q[1];
                5'd5:    rd_data = PARTNER_VAL;
                5'd9:    rd_data = GIG_CTRL;
                5'd10:   rd_data = GIG_STATUS;
                5'd16:   rd_data = rw_q[2];
                5'd17:   rd_data[LIVE_BIT] = live;
                default: rd_data = '0;
            endcase
        end
    end

    p_dead_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc != ACC_RW && acc != ACC_RO) |-> rd_data == '0);

    p_gig_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'd10) |-> rd_data == 16'h3C00);

    p_other_read_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != 5'd1 && link_up) |=> $stable(latched));

endmodule

// File: tb/test_phy_mgmt_regfile.sv
`timescale 1ns/1ps
module test_phy_mgmt_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic [15:0] ext_id = 16'hA5C3;
    logic        link_up = 1'b0;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] m_ctrl = 16'h1140;
    logic [15:0] m_adv  = 16'h01E1;
    logic [15:0] m_psc  = 16'h0068;
    logic        m_live = 1'b0;
    logic        m_lat  = 1'b0;

    always #10 clk = ~clk;

    phy_mgmt_regfile i_phy_mgmt_regfile (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .ext_id(ext_id), .link_up(link_up)
    );

    function automatic logic [15:0] expect_of(input logic [4:0] a);
        case (a)
            5'd0:    return m_ctrl;
            5'd1:    return 16'h7969 | (16'(m_lat) << 2);
            5'd2:    return 16'h0141;
            5'd3:    return ext_id;
            5'd4:    return m_adv;
            5'd5:    return 16'h01E0;
            5'd9:    return 16'h1E00;
            5'd10:   return 16'h3C00;
            5'd16:   return m_psc;
            5'd17:   return 16'(m_live) << 10;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'd0:                          return "R3";
            5'd4, 5'd16:                   return "R2";
            5'd1:                          return "R7";
            5'd2, 5'd3, 5'd5, 5'd9, 5'd10: return "R4";
            5'd17:                         return "R6";
            default:                       return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp,
                         input logic [4:0] a);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr %0d: actual %h expected %h", req, a, act, exp);
        end
    endtask

    task automatic peek(input logic [4:0] a, input string req);
        addr = a;
        #1;
        check(req, rd_data, expect_of(a), a);
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 32; a++) begin
            peek(5'(a), (req == "") ? tag_of(5'(a)) : req);
        end
    endtask

    task automatic write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 5'd0 && !d[15]) m_ctrl = d;
        if (a == 5'd4)  m_adv = d;
        if (a == 5'd16) m_psc = d;
    endtask

    task automatic strobe_read(input logic [4:0] a, input string req);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        check(req, rd_data, expect_of(a), a);
        @(negedge clk);
        rd_en = 1'b0;
        if (a == 5'd1 && link_up) m_lat = m_live;
        if (!link_up) begin m_live = 1'b0; m_lat = 1'b0; end
        else m_live = 1'b1;
    endtask

    task automatic set_link(input logic v);
        @(negedge clk);
        link_up = v;
        @(negedge clk);
        if (!v) begin m_live = 1'b0; m_lat = 1'b0; end
        else m_live = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values across the whole map
        sweep("R1");

        // R2 R3 R4 R5: write each address, then read back everything
        for (int a = 0; a < 32; a++) begin
            write(5'(a), 16'h5A00 ^ (16'(a) * 16'h0111));
            sweep("");
        end

        // R3: guard bit discards control writes
        write(5'd0, 16'h8123);
        peek(5'd0, "R3");
        write(5'd0, 16'h2100);
        peek(5'd0, "R3");
        write(5'd0, 16'hFFFF);
        peek(5'd0, "R3");

        // R9: combinational ext_id path
        ext_id = 16'h1234;
        peek(5'd3, "R9");
        ext_id = 16'hFEDC;
        peek(5'd3, "R9");

        // R7: status read while down keeps the bit low
        strobe_read(5'd1, "R7");
        peek(5'd1, "R7");

        // R6 R7: link comes up, latch stays low
        set_link(1'b1);
        peek(5'd17, "R6");
        peek(5'd1, "R7");

        // R9: strobes at other addresses do not refresh the latch
        strobe_read(5'd2, "R9");
        strobe_read(5'd17, "R9");
        peek(5'd1, "R9");

        // R7: first status read returns latched low, then high
        strobe_read(5'd1, "R7");
        peek(5'd1, "R7");
        strobe_read(5'd1, "R7");

        // R8: drop clears without a read
        set_link(1'b0);
        peek(5'd1, "R8");
        peek(5'd17, "R6");

        // R8: up, then down before any read
        set_link(1'b1);
        set_link(1'b0);
        strobe_read(5'd1, "R8");
        peek(5'd1, "R8");

        // R7: up again, refresh and confirm
        set_link(1'b1);
        strobe_read(5'd1, "R7");
        peek(5'd1, "R7");
        sweep("");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule